// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider Control

This block is the digital sequencing logic of a two-modulus feedback divider. A swallow count A (4 bits) and a program count B (12 bits) describe one output period of N = P·B + A input clocks, where P is the prescaler modulus. The prescaler is modelled inside the block as a small counter whose length is P+1 or P, chosen by a modulus-control signal. During each output period it runs A rounds of P+1 clocks first, and then B−A rounds of P clocks.

A mode input picks between a wide range (P = 16, full 4-bit swallow count) and a narrow range (P = 8, only the low 3 bits of the swallow count used). The block emits a one-clock pulse that closes each period. Swallow count, program count and mode are sampled only on that closing clock. Settings that would not give a continuous divide range are refused: a flag is raised and the divider keeps running with its last accepted settings.

Top module: `psw_divider`

## Requirements
- R1: With narrow_mode low, the distance between consecutive div_pulse assertions is 16·prog_cnt + swal_cnt input clocks, with swal_cnt using all 4 bits.
- R2: With narrow_mode high, the distance between consecutive pulses is 8·prog_cnt + swal_cnt[2:0]; swal_cnt[3] has no effect on the period.
- R3: div_pulse is high for exactly one input clock per period, on the last clock of the period.
- R4: swal_cnt, prog_cnt and narrow_mode are sampled only on a clock where div_pulse is high. They govern the period that starts on the next clock, and changes made at any other time do not alter the period in progress.
- R5: In wide mode, a setting with N < 240 or effective A > B is refused. cfg_invalid goes high on the clock after the sampling pulse, and the next period keeps the last accepted N.
- R6: In narrow mode, a setting with N < 56 or effective A > B is refused in the same way. N = 56 in narrow mode and N = 240 in wide mode are accepted.
- R7: cfg_invalid returns low on the clock after a sampling pulse that accepts a legal setting.
- R8: While rst_n is low, div_pulse and cfg_invalid are low. After reset, the active setting is wide mode with B = 15 and A = 0, so the first pulse falls on the 240th clock counted from the first clock with rst_n high.
- R9: The top of each range is reachable: wide mode B = 4095, A = 15 gives 65535 clocks, and narrow mode B = 4095, A = 7 gives 32767 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Synchronous reset, active low |
| narrow_mode | input | 1 | 1 selects prescaler modulus 8 and a 3-bit swallow count; 0 selects modulus 16 and a 4-bit count |
| swal_cnt | input | 4 | Swallow count A |
| prog_cnt | input | 12 | Program count B |
| div_pulse | output | 1 | One-clock pulse on the last clock of each divide period |
| cfg_invalid | output | 1 | High while the most recently sampled setting was refused |

## Verification
Every result is measured from a pulse. Settings present on a pulse clock govern the count of clocks up to the next pulse, and the refusal flag is due one clock after that pulse. The bench changes inputs only at the falling edge of a pulse clock, or on purpose in the middle of a period. It counts falling edges from one pulse to the next and compares that count with P·B + A, worked out from the last accepted setting. Sweeps cover every swallow value at each mode's minimum program count, random legal settings in both modes, both range tops, and the refused settings just below each minimum.

// File: rtl/psw_divider_pkg.sv
// Package: shared widths, configuration type and mode-dependent constants
// for the pulse-swallow divider. Assumes the narrow modulus is below the wide one.
package psw_divider_pkg;

    localparam int SWAL_W     = 4;
    localparam int PROG_W     = 12;
    localparam int NDIV_W     = 16;
    localparam int WIDE_LOG   = 4;
    localparam int NARROW_LOG = 3;
    localparam int PRE_W      = WIDE_LOG + 1;

    typedef struct packed {
        logic              narrow;
        logic [SWAL_W-1:0] swal;
        logic [PROG_W-1:0] prog;
    } div_cfg_t;

    // Prescaler base modulus P for the given mode.
    function automatic logic [PRE_W-1:0] pre_modulus(input logic narrow);
        return narrow ? PRE_W'(1 << NARROW_LOG) : PRE_W'(1 << WIDE_LOG);
    endfunction

    // Smallest N giving a continuous divide range: P*(P-1).
    function automatic logic [NDIV_W:0] min_total(input logic narrow);
        int p;
        p = narrow ? (1 << NARROW_LOG) : (1 << WIDE_LOG);
        return (NDIV_W+1)'(p * (p - 1));
    endfunction

endpackage

// File: rtl/psw_cfg_guard.sv
// Module: psw_cfg_guard
// Checks a requested setting against the mode rules and holds the active
// setting. The active setting and refusal flag change only when load is high.
// Assumes load is the one-clock end-of-period pulse.
module psw_cfg_guard
    import psw_divider_pkg::*;
#(
    parameter logic [SWAL_W-1:0] RST_SWAL = '0,
    parameter logic [PROG_W-1:0] RST_PROG = PROG_W'(15)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              narrow_in,
    input  logic [SWAL_W-1:0] swal_in,
    input  logic [PROG_W-1:0] prog_in,
    output div_cfg_t          act_cfg,
    output logic              refused
);

    localparam logic [SWAL_W-1:0] NARROW_MASK = SWAL_W'((1 << NARROW_LOG) - 1);

    logic [SWAL_W-1:0] swal_eff;
    logic [NDIV_W:0]   total_req;
    logic              req_ok;

    // Masks the swallow count for the mode and forms the requested N.
    always_comb begin
        swal_eff  = narrow_in ? (swal_in & NARROW_MASK) : swal_in;
        total_req = ((NDIV_W+1)'(prog_in) << (narrow_in ? NARROW_LOG : WIDE_LOG))
                    + (NDIV_W+1)'(swal_eff);
        req_ok    = (PROG_W'(swal_eff) <= prog_in) && (total_req >= min_total(narrow_in));
    end

    // Takes the request at the period boundary if legal, else flags it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cfg.narrow <= 1'b0;
            act_cfg.swal   <= RST_SWAL;
            act_cfg.prog   <= RST_PROG;
            refused        <= 1'b0;
        end else if (load) begin
            if (req_ok) begin
                act_cfg.narrow <= narrow_in;
                act_cfg.swal   <= swal_eff;
                act_cfg.prog   <= prog_in;
                refused        <= 1'b0;
            end else begin
                refused        <= 1'b1;
            end
        end
    end

    // R4
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_cfg));
    // R5
    act_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        PROG_W'(act_cfg.swal) <= act_cfg.prog);
    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(refused));

endmodule

// File: rtl/psw_prescaler.sv
// Module: psw_prescaler
// Behavioural model of the two-modulus prescaler: counts P+1 clocks per round
// while swallow is high and P clocks otherwise. wrap marks a round's last clock.
module psw_prescaler
    import psw_divider_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             narrow,
    input  logic             swallow,
    output logic             wrap,
    output logic [PRE_W-1:0] pre_cnt
);

    logic [PRE_W-1:0] last_val;

    // Picks the terminal count for the current modulus.
    always_comb begin
        last_val = pre_modulus(narrow) - PRE_W'(1) + PRE_W'(swallow);
        wrap     = (pre_cnt == last_val);
    end

    // Advances the round counter and restarts it on the last clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_cnt <= '0;
        else if (wrap)
            pre_cnt <= '0;
        else
            pre_cnt <= pre_cnt + PRE_W'(1);
    end

    // R1
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= pre_modulus(narrow));

endmodule

// File: rtl/psw_swallow_ctrl.sv
// Module: psw_swallow_ctrl
// Counts prescaler rounds within a period. It asks for the long modulus during
// the first A rounds and flags the period end on the last clock of round B.
// Assumes B >= 7 and A <= B, which the guard enforces.
module psw_swallow_ctrl
    import psw_divider_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  div_cfg_t cfg,
    input  logic     pre_wrap,
    output logic     swallow,
    output logic     period_end
);

    logic [PROG_W-1:0] round_cnt;

    // Derives the modulus request and the end-of-period condition.
    always_comb begin
        swallow    = (round_cnt < PROG_W'(cfg.swal));
        period_end = pre_wrap && (round_cnt == cfg.prog - PROG_W'(1));
    end

    // Steps the round count on each prescaler wrap and restarts it each period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            round_cnt <= '0;
        else if (period_end)
            round_cnt <= '0;
        else if (pre_wrap)
            round_cnt <= round_cnt + PROG_W'(1);
    end

    // R3
    round_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        round_cnt < cfg.prog);

endmodule

// File: rtl/psw_divider.sv
// Module: psw_divider (top)
// Pulse-swallow divider control: one pulse every P*B + A input clocks, with the
// settings sampled only on the pulse clock. Assumes a synchronous active-low reset.
module psw_divider
    import psw_divider_pkg::*;
#(
    parameter logic [SWAL_W-1:0] RST_SWAL = '0,
    parameter logic [PROG_W-1:0] RST_PROG = PROG_W'(15)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow_mode,
    input  logic [SWAL_W-1:0] swal_cnt,
    input  logic [PROG_W-1:0] prog_cnt,
    output logic              div_pulse,
    output logic              cfg_invalid
);

    div_cfg_t         act_cfg;
    logic             swallow;
    logic             pre_wrap;
    logic             period_end;
    logic [PRE_W-1:0] pre_cnt;

    psw_cfg_guard #(
        .RST_SWAL (RST_SWAL),
        .RST_PROG (RST_PROG)
    ) guard_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (period_end),
        .narrow_in (narrow_mode),
        .swal_in   (swal_cnt),
        .prog_in   (prog_cnt),
        .act_cfg   (act_cfg),
        .refused   (cfg_invalid)
    );

    psw_prescaler pre_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .narrow  (act_cfg.narrow),
        .swallow (swallow),
        .wrap    (pre_wrap),
        .pre_cnt (pre_cnt)
    );

    psw_swallow_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (act_cfg),
        .pre_wrap   (pre_wrap),
        .swallow    (swallow),
        .period_end (period_end)
    );

    // Drives the output pulse from the period-end condition.
    always_comb div_pulse = period_end;

    // R3
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);
    // R1
    long_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_cnt == pre_modulus(act_cfg.narrow)) |-> swallow);

endmodule

// File: tb/psw_divider_tb_top.sv
module psw_divider_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        narrow_mode = 1'b0;
    logic [3:0]  swal_cnt = '0;
    logic [11:0] prog_cnt = '0;
    logic        div_pulse;
    logic        cfg_invalid;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    psw_divider dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .narrow_mode (narrow_mode),
        .swal_cnt    (swal_cnt),
        .prog_cnt    (prog_cnt),
        .div_pulse   (div_pulse),
        .cfg_invalid (cfg_invalid)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual cycles=%0d expected below 190000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
            $finish;
        end
    end

    function automatic int n_of(input bit nar, input int a, input int b);
        return nar ? (8 * b + (a & 7)) : (16 * b + a);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts falling edges until the next pulse; records the flag one clock in.
    task automatic count_to_pulse(output int n, output bit flag1);
        n = 0;
        flag1 = 1'b0;
        do begin
            @(negedge clk);
            n = n + 1;
            if (n == 1) flag1 = cfg_invalid;
        end while (!div_pulse);
    endtask

    // Called at a pulse falling edge: drives a setting, measures the next period.
    task automatic run_cfg(input bit nar, input int a, input int b, input int exp,
                           input int exp_flag, input string req);
        int n;
        bit f;
        narrow_mode = nar;
        swal_cnt    = 4'(a);
        prog_cnt    = 12'(b);
        count_to_pulse(n, f);
        check(req, n, exp);
        check({req, " flag"}, int'(f), exp_flag);
    endtask

    initial begin
        int n;
        bit f;
        int last_n;
        // R8: reset state
        narrow_mode = 1'b0;
        swal_cnt    = 4'd0;
        prog_cnt    = 12'd15;
        repeat (4) @(negedge clk);
        check("R8 pulse in reset", int'(div_pulse), 0);
        check("R8 flag in reset", int'(cfg_invalid), 0);
        rst_n = 1'b1;
        // State at this falling edge is clock 1 of 240; pulse lands on clock 240.
        n = 0;
        while (!div_pulse) begin
            @(negedge clk);
            n = n + 1;
        end
        check("R8 first period", n + 1, 240);

        // R1: every swallow value at the wide minimum program count
        for (int a = 0; a < 16; a++)
            run_cfg(1'b0, a, 15, n_of(1'b0, a, 15), 0, "R1 sweep");
        // R2: every narrow swallow value with bit 3 set, which must be ignored
        for (int a = 0; a < 8; a++)
            run_cfg(1'b1, a | 8, 7, n_of(1'b1, a, 7), 0, "R2 sweep");
        // R1, R2: random legal settings
        for (int i = 0; i < 12; i++) begin
            int b;
            int a;
            b = 15 + int'($urandom_range(0, 40));
            a = int'($urandom_range(0, 15));
            run_cfg(1'b0, a, b, n_of(1'b0, a, b), 0, "R1 random");
            b = 7 + int'($urandom_range(0, 40));
            a = int'($urandom_range(0, 15));
            run_cfg(1'b1, a, b, n_of(1'b1, a, b), 0, "R2 random");
        end

        // R6: narrow boundary accepted, just below refused
        run_cfg(1'b1, 0, 7, 56, 0, "R6 min accepted");
        run_cfg(1'b1, 7, 6, 56, 1, "R6 below min refused");
        // R7: legal setting clears flag
        run_cfg(1'b0, 0, 15, 240, 0, "R7 clear");
        // R5: wide refused settings keep N = 240
        run_cfg(1'b0, 15, 14, 240, 1, "R5 A>B refused");
        run_cfg(1'b0, 0, 14, 240, 1, "R5 below min refused");
        run_cfg(1'b0, 3, 20, 323, 0, "R7 accept after refuse");
        last_n = 323;

        // R4: mid-period change does not affect the running period
        narrow_mode = 1'b0;
        swal_cnt    = 4'd5;
        prog_cnt    = 12'd18;
        n = 0;
        do begin
            @(negedge clk);
            n = n + 1;
            if (n == 40) begin
                narrow_mode = 1'b1;
                swal_cnt    = 4'd2;
                prog_cnt    = 12'd9;
            end
        end while (!div_pulse);
        check("R4 current period", n, 16 * 18 + 5);
        count_to_pulse(n, f);
        check("R4 next period", n, 8 * 9 + 2);
        check("R3 width", int'(div_pulse), 1);
        @(negedge clk);
        check("R3 width", int'(div_pulse), 0);
        while (!div_pulse) @(negedge clk);
        check("R4 prior", last_n, 323);

        // R9: range tops
        run_cfg(1'b0, 15, 4095, 65535, 0, "R9 wide max");
        run_cfg(1'b1, 7, 4095, 32767, 0, "R9 narrow max");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule